// File: doc/BRIEF.md
# Serial Right Shifter with Count Fallback

This block performs a logical right shift of a 32-bit operand by moving it one bit position per clock. A 5-bit count register sets how many positions it moves, and it also serves as the loop counter. A start strobe takes in the operand, a 5-bit immediate count and a 5-bit register-sourced count. The immediate count is used when it is nonzero. When it is zero, the block reloads the count from the register-sourced value in the following step. The accumulator then shifts right with zero fill and the count goes down by one on each clock, until the count reaches zero. The block then raises a one-cycle done pulse and holds the result on its output.

A controller sends the block one request at a time. It waits for `done_o` before sending the next start. Starts that arrive while the block is busy are dropped. The latency depends on the data: n + 2 cycles, where n is the selected count.

Top module: `serial_rshift`

## Requirements
- R1: A synchronous reset, active high, clears the count, the accumulator and the busy state. After reset `busy_o`=0, `done_o`=0 and `result_o`=0.
- R2: When the immediate count captured at start is nonzero, it is the shift count, and the register-sourced count has no effect on the result.
- R3: When the immediate count is zero, the shift count is bits 4..0 of the register-sourced count, which is presented on `reg_cnt_i`.
- R4: Each shift step moves the accumulator right by one bit, fills bit 31 with zero and lowers the count by one, so the result equals operand >> n (a logical shift).
- R5: `busy_o` is high from the cycle after an accepted start until done. `done_o` rises exactly n + 2 clock edges after the edge that accepts the start.
- R6: When both counts are zero, the result equals the operand unchanged, and `done_o` rises 2 edges after the start edge, with no shift steps.
- R7: `done_o` stays high for exactly one cycle. In the next cycle the block is idle, with `busy_o`=0.
- R8: A start that arrives while busy is ignored. The running operation keeps its result and its latency.
- R9: After done, `result_o` holds its value until the next accepted start.
- R10: Operand and counts are captured on the start edge. Changing them later during the operation has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, accepted only when idle |
| imm_cnt_i | input | 5 | Immediate shift count |
| reg_cnt_i | input | 5 | Fallback count, taken from the low bits of a register operand |
| opnd_i | input | 32 | Value to shift |
| result_o | output | 32 | Shifted value, held after done |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
The assertions assume that `start_i` and the data inputs are synchronous to `clk`, and that reset is asserted at the first edge. They also assume that data inputs matter only on the edge that accepts a start. The stimulus therefore drives every input on the falling edge. It also changes the operand and both counts right after each accepted start, and fires stray starts during the shift loop, so that any late sampling shows up in the result or in the latency. Both counts are drawn from the full 0..31 range, including the case where both are zero.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FALLBACK = 2'd1,
    ST_SHIFT    = 2'd2,
    ST_DONE     = 2'd3
  } shr_state_e;
endpackage

// File: rtl/shr_count.sv
module shr_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_imm,
  input  logic [CNT_W-1:0] imm_i,
  input  logic [CNT_W-1:0] alt_i,
  input  logic             load_alt,
  input  logic             dec,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] alt_q;

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      alt_q <= '0;
    end else if (load_imm) begin
      cnt_q <= imm_i;
      alt_q <= alt_i;
    end else if (load_alt) begin
      cnt_q <= alt_q;
    end else if (dec) begin
      cnt_q <= count_down(cnt_q);
    end
  end

  assign cnt_zero = (cnt_q == '0);

  // R4: the controller never decrements an empty count
  assert_dec_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    dec |-> !cnt_zero);

  // R4: each decrement lowers the count by exactly one
  assert_dec_by_one_R4: assert property (@(posedge clk) disable iff (rst)
    (dec && !load_imm && !load_alt) |=> (cnt_q + CNT_W'(1)) == $past(cnt_q));

  // R3: the fallback reload takes the value captured at start
  assert_fallback_load_R3: assert property (@(posedge clk) disable iff (rst)
    (load_alt && !load_imm) |=> cnt_q == $past(alt_q));
endmodule

// File: rtl/shr_acc.sv
module shr_acc #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              shift_en,
  output logic [DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] acc_q;

  function automatic logic [DATA_W-1:0] step_right(input logic [DATA_W-1:0] v);
    return {1'b0, v[DATA_W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (load)     acc_q <= opnd_i;
    else if (shift_en) acc_q <= step_right(acc_q);
  end

  assign acc_o = acc_q;

  // R4: one shift step equals a logical shift by one
  assert_step_logical_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load) |=> acc_q == ($past(acc_q) >> 1));

  // R9: the accumulator holds its value when it is neither loaded nor shifted
  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load) |=> $stable(acc_q));
endmodule

// File: rtl/shr_ctrl.sv
module shr_ctrl
  import shr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic cnt_zero_i,
  output logic load_o,
  output logic fallback_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o
);
  shr_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    fallback_o = 1'b0;
    shift_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = ST_FALLBACK;
      end
      ST_FALLBACK: begin
        fallback_o = cnt_zero_i;
        state_d    = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (cnt_zero_i) state_d = ST_DONE;
        else            shift_o = 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  // R7: done lasts exactly one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o && !busy_o);

  // R8: a start during the run does not disturb it
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o && start_i) |=> busy_o);

  // R5: done is preceded by a busy cycle without done
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: rtl/serial_rshift.sv
module serial_rshift #(
  parameter  int DATA_W = 32,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [CNT_W-1:0]  reg_cnt_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] result_o,
  output logic              busy_o,
  output logic              done_o
);
  logic load_w;
  logic fallback_w;
  logic shift_w;
  logic cnt_zero_w;

  shr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cnt_zero_i (cnt_zero_w),
    .load_o     (load_w),
    .fallback_o (fallback_w),
    .shift_o    (shift_w),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  shr_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load_imm (load_w),
    .imm_i    (imm_cnt_i),
    .alt_i    (reg_cnt_i),
    .load_alt (fallback_w),
    .dec      (shift_w),
    .cnt_zero (cnt_zero_w)
  );

  shr_acc #(.DATA_W(DATA_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .load     (load_w),
    .opnd_i   (opnd_i),
    .shift_en (shift_w),
    .acc_o    (result_o)
  );

  // R1: reset leaves the block idle with a cleared result
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && result_o == '0));

  // R9: while idle and not started, the result holds
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(result_o));

  // R10: an accepted start only happens from idle
  assert_start_from_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o && !done_o);
endmodule

// File: tb/test_serial_rshift.sv
module test_serial_rshift;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [4:0]  imm_cnt_i = '0;
  logic [4:0]  reg_cnt_i = '0;
  logic [31:0] opnd_i = '0;
  logic [31:0] result_o;
  logic        busy_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  serial_rshift i_serial_rshift (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .imm_cnt_i (imm_cnt_i),
    .reg_cnt_i (reg_cnt_i),
    .opnd_i    (opnd_i),
    .result_o  (result_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  localparam int NV = 8;
  localparam logic [31:0] V_OP  [NV] = '{32'hF000_000F, 32'h8000_0001, 32'hDEAD_BEEF, 32'h1234_5678,
                                         32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h8000_0000, 32'h0000_0002};
  localparam logic [4:0]  V_IMM [NV] = '{5'd4, 5'd31, 5'd0, 5'd0, 5'd1, 5'd0, 5'd16, 5'd0};
  localparam logic [4:0]  V_REG [NV] = '{5'd9, 5'd0, 5'd8, 5'd0, 5'd31, 5'd31, 5'd3, 5'd1};
  localparam logic [31:0] V_RES [NV] = '{32'h0F00_0000, 32'h0000_0001, 32'h00DE_ADBE, 32'h1234_5678,
                                         32'h7FFF_FFFF, 32'h0000_0001, 32'h0000_8000, 32'h0000_0001};
  localparam int          V_N   [NV] = '{4, 31, 8, 0, 1, 31, 16, 1};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Starts one operation; stray_at > 0 fires a start during the run at that cycle
  task automatic run_op(input logic [31:0] op, input logic [4:0] imm, input logic [4:0] rg,
                        input logic [31:0] exp_res, input int n, input int stray_at, input string tag);
    int k;
    @(negedge clk);
    start_i = 1'b1; opnd_i = op; imm_cnt_i = imm; reg_cnt_i = rg;
    @(negedge clk);
    start_i = 1'b0;
    // R10: scramble inputs after capture
    opnd_i = ~op; imm_cnt_i = imm ^ 5'h15; reg_cnt_i = rg ^ 5'h0A;
    check(busy_o === 1'b1 && done_o === 1'b0, {tag, " R5 busy after start"}, {30'b0, busy_o, done_o}, 32'h2);
    k = 0;
    while (done_o !== 1'b1 && k < 40) begin
      if (stray_at != 0 && k == stray_at) begin
        start_i = 1'b1; opnd_i = 32'h5555_AAAA; imm_cnt_i = 5'd2;
      end
      @(negedge clk);
      start_i = 1'b0;
      k++;
    end
    check(k == n + 2, {tag, " R5 latency"}, k, n + 2);
    check(result_o === exp_res, {tag, " R4 result"}, result_o, exp_res);
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0, {tag, " R7 single pulse"}, {30'b0, busy_o, done_o}, 32'h0);
    @(negedge clk);
    check(result_o === exp_res, {tag, " R9 result held"}, result_o, exp_res);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(busy_o === 1'b0 && done_o === 1'b0 && result_o === 32'h0, "R1 reset state",
          result_o, 32'h0);

    // Vector table: R2 nonzero immediate, R3 fallback, R6 both zero
    for (int i = 0; i < NV; i++)
      run_op(V_OP[i], V_IMM[i], V_REG[i], V_RES[i], V_N[i], 0,
             (V_IMM[i] != 0) ? "R2 vector" : ((V_REG[i] != 0) ? "R3 vector" : "R6 vector"));

    // R8: stray start during the shift loop is ignored
    run_op(32'hC000_0000, 5'd10, 5'd0, 32'h0030_0000, 10, 4, "R8 stray start");

    // R2: same immediate, different register counts, same result
    run_op(32'h0000_FF00, 5'd8, 5'd1, 32'h0000_00FF, 8, 0, "R2 reg ignored a");
    run_op(32'h0000_FF00, 5'd8, 5'd30, 32'h0000_00FF, 8, 0, "R2 reg ignored b");

    // R1: reset in the middle of an operation
    @(negedge clk);
    start_i = 1'b1; opnd_i = 32'hFFFF_0000; imm_cnt_i = 5'd20; reg_cnt_i = 5'd0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy_o === 1'b0 && done_o === 1'b0 && result_o === 32'h0, "R1 mid-run reset",
          result_o, 32'h0);
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && result_o === 32'h0, "R1 stays idle after reset", result_o, 32'h0);

    // R6 after reset: both counts zero
    run_op(32'h8765_4321, 5'd0, 5'd0, 32'h8765_4321, 0, 0, "R6 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule